// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control core of a small stored-program machine. Instructions and data share one memory port. The port uses a request/ready handshake, and the memory may take any number of cycles to answer. The sequencer fetches a word into its instruction register and advances the next-instruction pointer in the same edge. It then decodes the word. It reads a memory operand only when the opcode needs one. It computes the result in a four-register file with an integer ALU, and it either writes the result back to a register or stores it to memory. After that it returns to fetch.

The current phase is visible on the ports so that integration logic can follow the machine. The pointer is visible for the same reason. A write-back port shows each register write in the cycle it commits.

Top module: `fetch_exec_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, phase_o is FETCH (encoding FETCH=0, DECODE=1, OPRD=2, EXEC=3, WBACK=4, STORE=5), nip_o equals START_ADDR, wb_valid_o is low, and the first request addresses START_ADDR.
- R2: In every memory phase (FETCH, OPRD, STORE), mem_req_o stays high until mem_ready_i is seen at a rising edge. mem_addr_o and mem_we_o hold still during the wait. A memory that answers after L wait cycles therefore keeps the phase for L+1 cycles.
- R3: The fetch completes on the edge that samples mem_ready_i. On that edge the returned word is loaded into the instruction register and nip_o increments by one, so DECODE already shows the incremented pointer.
- R4: An instruction word is {opcode[15:12], target[11:10], source[9:8], addr[7:0]}. Register-only opcodes go FETCH, DECODE, EXEC, WBACK and skip OPRD: 0 ADD (target+source), 1 AND, 2 OR, 3 XOR, 4 NEG (two's complement of source).
- R5: Opcodes 5 ADDM (target + mem[addr]) and 6 LDM (mem[addr]) go FETCH, DECODE, OPRD, EXEC, WBACK. OPRD reads the address field.
- R6: The ALU results are, with 16-bit wraparound: the sum for ADD and ADDM, the bitwise result for AND, OR and XOR, the negation for NEG, and the memory word for LDM.
- R7: The result is latched in EXEC and committed in the following WBACK cycle. Only then is wb_valid_o high, with wb_reg_o set to the target field and wb_data_o set to the result.
- R8: Opcode 7 STM goes FETCH, DECODE, EXEC, STORE. It writes the source register to the address field with mem_we_o high, and it writes no register.
- R9: Opcodes 8 to 15 return from DECODE straight to FETCH, write no register and make no data access.
- R10: At most one access is outstanding. mem_req_o is high only in FETCH, OPRD and STORE, and mem_we_o only in STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 8 | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes at this edge |
| phase_o | output | 3 | Current sequencer phase |
| nip_o | output | 8 | Next-instruction pointer |
| wb_valid_o | output | 1 | Register write commits this cycle |
| wb_reg_o | output | 2 | Register being written |
| wb_data_o | output | 16 | Value being written |

## Verification
With zero wait cycles, an instruction lasts a fixed number of cycles: two for an unknown opcode, four for a register-only operation or a store, and five for a memory-operand operation. Each wait cycle the memory inserts adds one cycle to the memory phase it falls in. The bench counts rising edges from reset release and derives the exact edge count at which each write-back must appear from these durations. It samples each write-back on the falling edge after that count and compares the register, the value and the edge count. Phase and pointer checks use the same count: the DECODE pointer one edge after a zero-latency fetch, and the held request two edges into a three-wait fetch.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_OPRD   = 3'd2,
    PH_EXEC   = 3'd3,
    PH_WBACK  = 3'd4,
    PH_STORE  = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_AND  = 3'd1,
    ALU_OR   = 3'd2,
    ALU_XOR  = 3'd3,
    ALU_NEG  = 3'd4,
    ALU_PASS = 3'd5
  } alu_op_e;

  localparam int unsigned OPC_W = 4;

  typedef struct packed {
    logic    valid;
    logic    mem_src;
    logic    is_store;
    alu_op_e op;
  } dec_t;

  function automatic dec_t decode_op(logic [OPC_W-1:0] opc);
    dec_t d;
    d.valid    = 1'b1;
    d.mem_src  = 1'b0;
    d.is_store = 1'b0;
    d.op       = ALU_ADD;
    case (opc)
      4'd0: d.op = ALU_ADD;
      4'd1: d.op = ALU_AND;
      4'd2: d.op = ALU_OR;
      4'd3: d.op = ALU_XOR;
      4'd4: d.op = ALU_NEG;
      4'd5: begin d.op = ALU_ADD;  d.mem_src = 1'b1; end
      4'd6: begin d.op = ALU_PASS; d.mem_src = 1'b1; end
      4'd7: begin d.op = ALU_PASS; d.is_store = 1'b1; end
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_NEG:  y_o = DATA_W'(0) - b_i;
      ALU_PASS: y_o = b_i;
      default:  y_o = '0;
    endcase
  end

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);

  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))   regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NREGS      = 4,
  parameter int unsigned START_ADDR = 16,
  localparam int unsigned IDX_W  = $clog2(NREGS),
  localparam int unsigned OPC_LSB = DATA_W - OPC_W,
  localparam int unsigned TGT_LSB = OPC_LSB - IDX_W,
  localparam int unsigned SRC_LSB = TGT_LSB - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output alu_op_e           alu_op_o,
  output logic              b_sel_mem_o,
  output logic [DATA_W-1:0] mdr_o,
  input  logic [DATA_W-1:0] alu_res_i,
  output logic [IDX_W-1:0]  tgt_o,
  output logic [IDX_W-1:0]  src_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output phase_e            phase_o,
  output logic [ADDR_W-1:0] nip_o
);

  phase_e            phase_q;
  logic [DATA_W-1:0] ir_q, mdr_q, alu_q;
  logic [ADDR_W-1:0] nip_q, mar_q;
  dec_t              dec;

  assign dec = decode_op(ir_q[DATA_W-1:OPC_LSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      nip_q   <= ADDR_W'(START_ADDR);
      ir_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      alu_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_FETCH: if (mem_ready_i) begin
          ir_q    <= mem_rdata_i;
          nip_q   <= nip_q + 1'b1;
          phase_q <= PH_DECODE;
        end
        PH_DECODE: begin
          mar_q <= ir_q[ADDR_W-1:0];
          if (!dec.valid)      phase_q <= PH_FETCH;
          else if (dec.mem_src) phase_q <= PH_OPRD;
          else                 phase_q <= PH_EXEC;
        end
        PH_OPRD: if (mem_ready_i) begin
          mdr_q   <= mem_rdata_i;
          phase_q <= PH_EXEC;
        end
        PH_EXEC: begin
          alu_q   <= alu_res_i;
          phase_q <= dec.is_store ? PH_STORE : PH_WBACK;
        end
        PH_WBACK: phase_q <= PH_FETCH;
        PH_STORE: if (mem_ready_i) phase_q <= PH_FETCH;
        default:  phase_q <= PH_FETCH;
      endcase
    end
  end

  assign mem_req_o   = (phase_q == PH_FETCH) || (phase_q == PH_OPRD) || (phase_q == PH_STORE);
  assign mem_we_o    = (phase_q == PH_STORE);
  assign mem_addr_o  = (phase_q == PH_FETCH) ? nip_q : mar_q;
  assign mem_wdata_o = alu_q;
  assign alu_op_o    = dec.op;
  assign b_sel_mem_o = dec.mem_src;
  assign mdr_o       = mdr_q;
  assign tgt_o       = ir_q[OPC_LSB-1:TGT_LSB];
  assign src_o       = ir_q[TGT_LSB-1:SRC_LSB];
  assign rf_we_o     = (phase_q == PH_WBACK);
  assign rf_wdata_o  = alu_q;
  assign phase_o     = phase_q;
  assign nip_o       = nip_q;

  // R2: a pending access keeps its request, address and direction
  p_hold_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_nip_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH && mem_ready_i) |=> (phase_q == PH_DECODE && nip_q == $past(nip_q) + 1'b1));

  p_regop_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DECODE && dec.valid && !dec.mem_src) |=> (phase_q == PH_EXEC));

  p_oprd_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_OPRD) |-> ($past(phase_q) == PH_DECODE));

  p_wb_after_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> ($past(phase_q) == PH_EXEC && $past(alu_res_i) == rf_wdata_o));

  p_store_no_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && dec.is_store) |=> (phase_q == PH_STORE && !rf_we_o));

  p_unknown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DECODE && !dec.valid) |=> (phase_q == PH_FETCH));

  p_write_in_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && $past(phase_q) != PH_FETCH));

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NREGS      = 4,
  parameter int unsigned START_ADDR = 16,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [2:0]        phase_o,
  output logic [ADDR_W-1:0] nip_o,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_reg_o,
  output logic [DATA_W-1:0] wb_data_o
);

  alu_op_e           alu_op;
  logic              b_sel_mem;
  logic [DATA_W-1:0] mdr, alu_res, rd_a, rd_b, rf_wdata;
  logic [IDX_W-1:0]  tgt, src;
  logic              rf_we;
  phase_e            phase;

  seq_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREGS(NREGS), .START_ADDR(START_ADDR)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i,
    .alu_op_o(alu_op), .b_sel_mem_o(b_sel_mem), .mdr_o(mdr), .alu_res_i(alu_res),
    .tgt_o(tgt), .src_o(src), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata),
    .phase_o(phase), .nip_o
  );

  seq_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(tgt), .wdata_i(rf_wdata),
    .raddr_a_i(tgt), .raddr_b_i(src),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b)
  );

  seq_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(alu_op), .a_i(rd_a), .b_i(b_sel_mem ? mdr : rd_b), .y_o(alu_res)
  );

  assign phase_o    = phase;
  assign wb_valid_o = rf_we;
  assign wb_reg_o   = tgt;
  assign wb_data_o  = rf_wdata;

endmodule

// File: tb/fetch_exec_seq_test.sv
module fetch_exec_seq_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [7:0]  mem_addr, nip;
  logic [15:0] mem_wdata, mem_rdata = '0, wb_data;
  logic [2:0]  phase;
  logic        wb_valid;
  logic [1:0]  wb_reg;

  int n_chk = 0, n_bad = 0;
  int lat = 0, cnt = 0, cyc = 0, n_wb = 0;
  logic [15:0] mem [256];
  logic [1:0]  wb_r [32];
  logic [15:0] wb_d [32];
  int          wb_c [32];

  localparam logic [7:0] START = 8'h10;

  always #4 clk = ~clk;

  fetch_exec_seq uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .phase_o(phase), .nip_o(nip),
    .wb_valid_o(wb_valid), .wb_reg_o(wb_reg), .wb_data_o(wb_data)
  );

  // memory model with lat wait cycles per access
  initial forever begin
    @(negedge clk);
    if (!rst_ni || !mem_req) begin
      mem_ready = 1'b0; cnt = 0;
    end else if (cnt >= lat) begin
      mem_ready = 1'b1; cnt = 0;
      mem_rdata = mem[mem_addr];
      if (mem_we) mem[mem_addr] = mem_wdata;
    end else begin
      mem_ready = 1'b0; cnt++;
    end
  end

  initial forever begin
    @(posedge clk);
    if (rst_ni) cyc++;
  end

  initial forever begin
    @(negedge clk);
    if (rst_ni && wb_valid && n_wb < 32) begin
      wb_r[n_wb] = wb_reg; wb_d[n_wb] = wb_data; wb_c[n_wb] = cyc; n_wb++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int op, int rd, int rs, int a);
    return {4'(op), 2'(rd), 2'(rs), 8'(a)};
  endfunction

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic restart(int l);
    rst_ni = 1'b0;
    lat = l;
    foreach (mem[i]) mem[i] = 16'hF000;
  endtask

  task automatic release_rst();
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    cyc = 0; n_wb = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    restart(0);
    mem[START] = enc(6, 1, 0, 8'h80);
    repeat (2) @(negedge clk);
    check("R1 phase in reset", 32'(phase), 0);
    check("R1 nip in reset", 32'(nip), 32'(START));
    check("R1 no wb in reset", 32'(wb_valid), 0);
    release_rst();
    check("R1 first addr", 32'(mem_addr), 32'(START));
    check("R10 first req read", 32'({mem_req, mem_we}), 32'b10);
    wait_cyc(1);
    check("R3 decode phase", 32'(phase), 1);
    check("R3 nip advanced", 32'(nip), 32'(START) + 1);
  endtask

  task automatic t_program();
    restart(0);
    mem[8'h80] = 16'h1234; mem[8'h81] = 16'h0F0F; mem[8'h82] = 16'h0040;
    mem[START+0]  = enc(6, 1, 0, 8'h80);
    mem[START+1]  = enc(6, 2, 0, 8'h81);
    mem[START+2]  = enc(0, 1, 2, 0);
    mem[START+3]  = enc(1, 2, 1, 0);
    mem[START+4]  = enc(2, 3, 1, 0);
    mem[START+5]  = enc(3, 3, 2, 0);
    mem[START+6]  = enc(4, 0, 3, 0);
    mem[START+7]  = enc(5, 0, 0, 8'h82);
    mem[START+8]  = enc(7, 0, 0, 8'h83);
    mem[START+9]  = 16'h9000;
    mem[START+10] = enc(0, 1, 1, 0);
    release_rst();
    wait_cyc(60);
    check("R9 wb count", 32'(n_wb), 9);
    check("R5 LDM value", 32'({wb_r[0], wb_d[0]}), {14'd0, 2'd1, 16'h1234});
    check("R5 LDM cycle", 32'(wb_c[0]), 4);
    check("R5 LDM2 value", 32'({wb_r[1], wb_d[1]}), {14'd0, 2'd2, 16'h0F0F});
    check("R6 ADD", 32'({wb_r[2], wb_d[2]}), {14'd0, 2'd1, 16'h2143});
    check("R4 ADD cycle", 32'(wb_c[2]), 13);
    check("R6 AND", 32'({wb_r[3], wb_d[3]}), {14'd0, 2'd2, 16'h0103});
    check("R6 OR", 32'({wb_r[4], wb_d[4]}), {14'd0, 2'd3, 16'h2143});
    check("R6 XOR", 32'({wb_r[5], wb_d[5]}), {14'd0, 2'd3, 16'h2040});
    check("R6 NEG", 32'({wb_r[6], wb_d[6]}), {14'd0, 2'd0, 16'hDFC0});
    check("R7 ADDM", 32'({wb_r[7], wb_d[7]}), {14'd0, 2'd0, 16'hE000});
    check("R7 ADDM cycle", 32'(wb_c[7]), 34);
    check("R8 STM memory", 32'(mem[8'h83]), 32'hE000);
    check("R9 ADD after unknown", 32'({wb_r[8], wb_d[8]}), {14'd0, 2'd1, 16'h4286});
    check("R9 unknown/store timing", 32'(wb_c[8]), 44);
  endtask

  task automatic t_latency();
    restart(3);
    mem[8'h80] = 16'hBEEF;
    mem[START+0] = enc(6, 1, 0, 8'h80);
    mem[START+1] = enc(7, 0, 1, 8'h84);
    release_rst();
    wait_cyc(2);
    check("R2 held phase", 32'(phase), 0);
    check("R2 held req/addr", 32'({mem_req, mem_ready, mem_addr}), {22'd0, 1'b1, 1'b0, START});
    wait_cyc(40);
    check("R2 wb cycle with waits", 32'(wb_c[0]), 10);
    check("R2 wb value with waits", 32'(wb_d[0]), 32'hBEEF);
    check("R8 store with waits", 32'(mem[8'h84]), 32'hBEEF);
    check("R8 store writes no reg", 32'(n_wb), 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule